// File: doc/BRIEF.md
# FIFO Flag Offset Programming Controller

This block sets the almost-empty and almost-full threshold offsets of two FIFOs that carry data in opposite directions. FIFO1 runs from port A to port B and FIFO2 runs from port B to port A. Each FIFO has its own active-low reset. At the first clock edge after a reset is released, the block samples a shared two-bit flag-select input.

A non-zero select code loads a fixed preset into both offsets of that FIFO only, and releases that FIFO at once. Code 00 on both resets released at the same clock edge arms a programming mode. In that mode the next four port-A writes are taken as offset values and are not passed to the FIFO1 memory. Both FIFOs are released only after the fourth value has been taken.

The four offsets are named as follows:
- `x1`: port-B almost-empty offset of FIFO1.
- `y1`: port-A almost-full offset of FIFO1.
- `x2`: port-A almost-empty offset of FIFO2.
- `y2`: port-B almost-full offset of FIFO2.

The capture sequencer has six states:
- ST_WAIT: entered on reset. It holds while preset mode is in use. Transition *arm* goes to ST_Y1 on a joint 00 release.
- ST_Y1, ST_X1, ST_Y2, ST_X2: capture states. Each takes one write and then follows transition *take* to the next state in that order.
- ST_RUN: entered from ST_X2 by transition *finish*. It holds until the next reset.

Any reset returns the sequencer to ST_WAIT through transition *abort*.

Top module: `fifo_ofs_ctrl`

## Requirements
- R1: Each FIFO's select code is sampled once, at the first rising clock edge after that FIFO's reset is released. Later changes of `fsel` have no effect on the offsets.
- R2: At that sample, code 2'b11 sets both offsets of the released FIFO to 64, code 2'b10 sets them to 16, and code 2'b01 sets them to 8. The matching done output (`done1` for FIFO1, `done2` for FIFO2) goes high at the same edge.
- R3: A reset or preset load of one FIFO leaves the other FIFO's two offsets and its done output unchanged.
- R4: Code 2'b00 on both resets released at the same edge arms programming. The next four cycles with `wr_en` high load, in order, `y1`, `x1`, `y2`, `x2`. During each of these writes `wr_pass` is low, and cycles with `wr_en` low do not advance the order.
- R5: A captured offset is taken from `wr_data[7:0]`, with bit 7 as the most significant bit. Bits 35:8 are ignored.
- R6: In programming mode, `done1` and `done2` stay low until the fourth capture and are both high after it. A later write leaves the offsets unchanged and drives `wr_pass` high.
- R7: A captured value of 0 is stored as 1, and a captured value above 252 is stored as 252. The values 1 to 252 are stored unchanged.
- R8: `ofs_err` goes high when a captured value is clamped. It stays high until both resets are asserted together.
- R9: Code 2'b00 sampled for one FIFO without a joint release loads 64 into both of that FIFO's offsets, sets its done output, and raises `ofs_err`.
- R10: While both resets are low, all offsets read 0, `done1` and `done2` are low, `ofs_err` is low and `wr_pass` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port-A clock |
| rst1_n | input | 1 | FIFO1 reset, active low, asynchronous assert |
| rst2_n | input | 1 | FIFO2 reset, active low, asynchronous assert |
| fsel | input | 2 | Flag-select code sampled on reset release |
| wr_en | input | 1 | Qualified port-A write to FIFO1 |
| wr_data | input | 36 | Port-A write data |
| wr_pass | output | 1 | Write forwarded to the FIFO1 memory |
| x1 | output | 8 | FIFO1 port-B almost-empty offset |
| y1 | output | 8 | FIFO1 port-A almost-full offset |
| x2 | output | 8 | FIFO2 port-A almost-empty offset |
| y2 | output | 8 | FIFO2 port-B almost-full offset |
| done1 | output | 1 | FIFO1 offsets valid, FIFO1 may run |
| done2 | output | 1 | FIFO2 offsets valid, FIFO2 may run |
| ofs_err | output | 1 | Sticky clamp or lone-00 error |

## Verification
Suppose the sequencer skips, repeats or stalls a state. The captured values then appear on the wrong offset outputs, or the done outputs rise one write early or late, and both show at the first clock edge after the fourth write. A select sampler that fires twice, or at the wrong time, shows as an offset changing while `fsel` moves after release, or as one FIFO's reset disturbing the other FIFO's outputs, visible one cycle after the release. A faulty clamp or error latch shows at the edge of the offending capture.

// File: rtl/fifo_ofs_pkg.sv
package fifo_ofs_pkg;
    typedef enum logic [2:0] {
        ST_WAIT,
        ST_Y1,
        ST_X1,
        ST_Y2,
        ST_X2,
        ST_RUN
    } seq_state_t;

    localparam logic [1:0] CODE_PROG = 2'b00;
    localparam logic [1:0] CODE_LOW  = 2'b01;
    localparam logic [1:0] CODE_MID  = 2'b10;
    localparam logic [1:0] CODE_HIGH = 2'b11;
endpackage

// File: rtl/ofs_rst_sampler.sv
module ofs_rst_sampler (
    input  logic clk,
    input  logic rst_n,
    output logic fire_o
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    assign fire_o = rst_n & ~seen_q;

    AST_SAMPLE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |=> (seen_q && !fire_o)); // R1
endmodule

// File: rtl/ofs_pair.sv
module ofs_pair #(
    parameter int OFS_W   = 8,
    parameter int OFS_MAX = 252
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_both_i,
    input  logic [OFS_W-1:0] both_val_i,
    input  logic             ld_ae_i,
    input  logic             ld_af_i,
    input  logic [OFS_W-1:0] prog_val_i,
    output logic [OFS_W-1:0] ae_o,
    output logic [OFS_W-1:0] af_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ae_o <= '0;
            af_o <= '0;
        end else if (ld_both_i) begin
            ae_o <= both_val_i;
            af_o <= both_val_i;
        end else begin
            if (ld_ae_i) ae_o <= prog_val_i;
            if (ld_af_i) af_o <= prog_val_i;
        end
    end

    AST_OFS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ae_o == '0 || (int'(ae_o) >= 1 && int'(ae_o) <= OFS_MAX))); // R7
endmodule

// File: rtl/ofs_seq.sv
module ofs_seq
    import fifo_ofs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       wr_en_i,
    output seq_state_t state_o,
    output logic       capture_o,
    output logic       last_o
);
    seq_state_t state_q, state_d;
    logic       in_cap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: if (start_i) state_d = ST_Y1;
            ST_Y1:   if (wr_en_i) state_d = ST_X1;
            ST_X1:   if (wr_en_i) state_d = ST_Y2;
            ST_Y2:   if (wr_en_i) state_d = ST_X2;
            ST_X2:   if (wr_en_i) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_WAIT;
        endcase
    end

    always_comb begin
        in_cap = 1'b0;
        unique case (state_q)
            ST_Y1, ST_X1, ST_Y2, ST_X2: in_cap = 1'b1;
            default:                    in_cap = 1'b0;
        endcase
        state_o   = state_q;
        capture_o = in_cap & wr_en_i;
        last_o    = in_cap & wr_en_i & (state_q == ST_X2);
    end

    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_Y1, ST_X1, ST_Y2, ST_X2}) && !wr_en_i |=> $stable(state_q)); // R4
    AST_ARM_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> state_q == ST_WAIT); // R4
endmodule

// File: rtl/fifo_ofs_ctrl.sv
module fifo_ofs_ctrl
    import fifo_ofs_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 36,
    localparam int OFS_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst1_n,
    input  logic              rst2_n,
    input  logic [1:0]        fsel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_pass,
    output logic [OFS_W-1:0]  x1,
    output logic [OFS_W-1:0]  y1,
    output logic [OFS_W-1:0]  x2,
    output logic [OFS_W-1:0]  y2,
    output logic              done1,
    output logic              done2,
    output logic              ofs_err
);
    localparam int OFS_MAX = DEPTH - 4;
    localparam logic [OFS_W-1:0] PRE_HIGH = OFS_W'(DEPTH / 4);
    localparam logic [OFS_W-1:0] PRE_MID  = OFS_W'(DEPTH / 16);
    localparam logic [OFS_W-1:0] PRE_LOW  = OFS_W'(DEPTH / 32);
    localparam logic [OFS_W-1:0] MAX_V    = OFS_W'(OFS_MAX);

    function automatic logic [OFS_W-1:0] preset_of(input logic [1:0] code);
        unique case (code)
            CODE_HIGH: preset_of = PRE_HIGH;
            CODE_MID:  preset_of = PRE_MID;
            CODE_LOW:  preset_of = PRE_LOW;
            default:   preset_of = PRE_HIGH;
        endcase
    endfunction

    logic rst_any_n, rst_all_n;
    assign rst_any_n = rst1_n & rst2_n;
    assign rst_all_n = rst1_n | rst2_n;

    logic [1:0] rst_n_v, fire_v, ld_both_v, lone_v, ld_ae_v, ld_af_v;
    logic [OFS_W-1:0] ae_v [2];
    logic [OFS_W-1:0] af_v [2];
    assign rst_n_v = {rst2_n, rst1_n};

    seq_state_t st;
    logic       cap, last, joint;
    logic [OFS_W-1:0] raw_val, prog_val;
    logic       clamp_hit;

    assign joint = fire_v[0] & fire_v[1] & (fsel == CODE_PROG) & (st == ST_WAIT);

    ofs_seq i_seq (
        .clk      (clk),
        .rst_n    (rst_any_n),
        .start_i  (joint),
        .wr_en_i  (wr_en),
        .state_o  (st),
        .capture_o(cap),
        .last_o   (last)
    );

    always_comb begin
        raw_val   = wr_data[OFS_W-1:0];
        clamp_hit = 1'b0;
        prog_val  = raw_val;
        if (raw_val == '0) begin
            prog_val  = OFS_W'(1);
            clamp_hit = 1'b1;
        end else if (raw_val > MAX_V) begin
            prog_val  = MAX_V;
            clamp_hit = 1'b1;
        end
    end

    assign ld_af_v[0] = cap & (st == ST_Y1);
    assign ld_ae_v[0] = cap & (st == ST_X1);
    assign ld_af_v[1] = cap & (st == ST_Y2);
    assign ld_ae_v[1] = cap & (st == ST_X2);

    logic [1:0] done_q;

    for (genvar g = 0; g < 2; g++) begin : g_side
        ofs_rst_sampler i_smp (
            .clk   (clk),
            .rst_n (rst_n_v[g]),
            .fire_o(fire_v[g])
        );

        assign ld_both_v[g] = fire_v[g] & ~joint;
        assign lone_v[g]    = ld_both_v[g] & (fsel == CODE_PROG);

        ofs_pair #(.OFS_W(OFS_W), .OFS_MAX(OFS_MAX)) i_pair (
            .clk       (clk),
            .rst_n     (rst_n_v[g]),
            .ld_both_i (ld_both_v[g]),
            .both_val_i(preset_of(fsel)),
            .ld_ae_i   (ld_ae_v[g]),
            .ld_af_i   (ld_af_v[g]),
            .prog_val_i(prog_val),
            .ae_o      (ae_v[g]),
            .af_o      (af_v[g])
        );

        always_ff @(posedge clk or negedge rst_n_v[g]) begin
            if (!rst_n_v[g])                 done_q[g] <= 1'b0;
            else if (ld_both_v[g] || last)   done_q[g] <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_all_n) begin
        if (!rst_all_n)                                  ofs_err <= 1'b0;
        else if ((cap && clamp_hit) || (|lone_v))        ofs_err <= 1'b1;
    end

    assign x1      = ae_v[0];
    assign y1      = af_v[0];
    assign x2      = ae_v[1];
    assign y2      = af_v[1];
    assign done1   = done_q[0];
    assign done2   = done_q[1];
    assign wr_pass = wr_en & done_q[0] & ~cap;

    AST_DONE_HAS_OFS: assert property (@(posedge clk) disable iff (!rst2_n)
        done2 |-> (x2 != '0 && y2 != '0)); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_all_n)
        ofs_err |=> ofs_err); // R8
    AST_OTHER_KEPT: assert property (@(posedge clk) disable iff (!rst_any_n)
        (fire_v[0] && !fire_v[1]) |=> ($stable(x2) && $stable(y2))); // R3
endmodule

// File: tb/test_fifo_ofs_ctrl.sv
module test_fifo_ofs_ctrl;
    logic clk = 1'b0;
    logic rst1_n = 1'b0, rst2_n = 1'b0;
    logic [1:0] fsel = 2'b00;
    logic wr_en = 1'b0;
    logic [35:0] wr_data = '0;
    logic wr_pass, done1, done2, ofs_err;
    logic [7:0] x1, y1, x2, y2;
    int total = 0, bad = 0;
    logic pass_seen;

    always #2.5 clk = ~clk;

    fifo_ofs_ctrl i_fifo_ofs_ctrl (
        .clk(clk), .rst1_n(rst1_n), .rst2_n(rst2_n), .fsel(fsel),
        .wr_en(wr_en), .wr_data(wr_data), .wr_pass(wr_pass),
        .x1(x1), .y1(y1), .x2(x2), .y2(y2),
        .done1(done1), .done2(done2), .ofs_err(ofs_err)
    );

    // {fsel for FIFO1, fsel for FIFO2, expected FIFO1 offset, expected FIFO2 offset}
    localparam logic [19:0] PRESET_VEC [3] = '{
        {2'b11, 2'b10, 8'd64, 8'd16},
        {2'b01, 2'b11, 8'd8,  8'd64},
        {2'b10, 2'b01, 8'd16, 8'd8}
    };

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rst_sep(input logic [1:0] f1, input logic [1:0] f2);
        @(negedge clk); rst1_n = 1'b0; rst2_n = 1'b0;
        repeat (4) @(negedge clk);
        fsel = f1; rst1_n = 1'b1;
        @(negedge clk); fsel = f2; rst2_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rst_joint(input logic [1:0] f);
        @(negedge clk); rst1_n = 1'b0; rst2_n = 1'b0;
        repeat (4) @(negedge clk);
        fsel = f; rst1_n = 1'b1; rst2_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [35:0] d);
        wr_en = 1'b1; wr_data = d;
        #1 pass_seen = wr_pass;
        @(negedge clk); wr_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        wr_en = 1'b1; #1;
        check("R10 offsets", {x1, y1, x2, y2}, 32'h0);
        check("R10 done/err/pass", {done1, done2, ofs_err, wr_pass}, 4'b0000);
        @(negedge clk); wr_en = 1'b0;

        // R2: preset table, FIFOs released one cycle apart
        for (int i = 0; i < 3; i++) begin
            rst_sep(PRESET_VEC[i][19:18], PRESET_VEC[i][17:16]);
            check("R2 FIFO1 pair", {x1, y1}, {PRESET_VEC[i][15:8], PRESET_VEC[i][15:8]});
            check("R2 FIFO2 pair", {x2, y2}, {PRESET_VEC[i][7:0], PRESET_VEC[i][7:0]});
            check("R2 done", {done1, done2, ofs_err}, 3'b110);
        end

        // R1: later fsel changes ignored
        fsel = 2'b11;
        repeat (3) @(negedge clk);
        check("R1 sampled once", {x1, y1, x2, y2}, {8'd16, 8'd16, 8'd8, 8'd8});

        // R4 R5 R6 R7 R8: programming with clamping
        rst_joint(2'b00);
        check("R6 done low armed", {done1, done2}, 2'b00);
        wr(36'hF_FFFF_FF05);
        check("R4 Y1 no pass", pass_seen, 1'b0);
        @(negedge clk); // idle cycle, order must hold
        wr(36'h0_0000_0000);
        check("R8 err after clamp", ofs_err, 1'b1);
        wr(36'h0_0000_00FD);
        check("R6 done low before fourth", {done1, done2}, 2'b00);
        wr(36'h0_0000_0107);
        check("R4 X2 no pass", pass_seen, 1'b0);
        check("R4 R5 y1", y1, 8'd5);
        check("R7 x1 zero clamps", x1, 8'd1);
        check("R7 y2 high clamps", y2, 8'd252);
        check("R5 x2 low byte", x2, 8'd7);
        check("R6 done after fourth", {done1, done2}, 2'b11);
        wr(36'h0_0000_0033);
        check("R6 fifth write passes", pass_seen, 1'b1);
        check("R6 offsets unchanged", {y1, x1, y2, x2}, {8'd5, 8'd1, 8'd252, 8'd7});
        check("R8 err sticky", ofs_err, 1'b1);

        // R7 R8: in-range boundaries, err cleared by joint reset
        rst_joint(2'b00);
        check("R8 err cleared", ofs_err, 1'b0);
        wr(36'd1); wr(36'd252); wr(36'd128); wr(36'd200);
        check("R7 exact values", {y1, x1, y2, x2}, {8'd1, 8'd252, 8'd128, 8'd200});
        check("R8 no err", ofs_err, 1'b0);

        // R3: reset FIFO1 alone with code 10
        @(negedge clk); rst1_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R3 done2 held during rst1", {done1, done2}, 2'b01);
        fsel = 2'b10; rst1_n = 1'b1;
        @(negedge clk);
        check("R3 FIFO1 reloaded", {x1, y1, done1}, {8'd16, 8'd16, 1'b1});
        check("R3 FIFO2 kept", {x2, y2, done2}, {8'd200, 8'd128, 1'b1});

        // R9: lone 00 on FIFO2
        @(negedge clk); rst2_n = 1'b0;
        repeat (4) @(negedge clk);
        fsel = 2'b00; rst2_n = 1'b1;
        @(negedge clk);
        check("R9 lone 00 pair", {x2, y2, done2}, {8'd64, 8'd64, 1'b1});
        check("R9 err raised", ofs_err, 1'b1);
        check("R3 FIFO1 kept", {x1, y1}, {8'd16, 8'd16});
        wr(36'd9);
        check("R9 write passes", pass_seen, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule